// File: doc/BRIEF.md
# Command Bus Parity Error Checker

This block watches the address/command bus of a registered DRAM interface and checks even parity over each command word. On every rising clock edge it captures a 22-bit word: sixteen address bits, three bank bits, and the RAS, CAS and WE lines. It captures the four active-low chip selects on the same edge. The parity bit for that word arrives one cycle later on its own input. The block XORs the word's bit sum with that late parity bit. Only a word for which some chip select was low can raise an error.

An error drives the active-low flag `perr_n` low three clock edges after the faulty word was captured. The flag then stays low for exactly two cycles. If another failing result reaches the end of the pipeline while the flag is low, the two-cycle window starts again, so the flag stays low without a break. A deselect cycle, in which all chip selects are high, passes through the same three-cycle pipeline and always yields a pass. An active-low reset clears the pipeline and holds the flag high.

Top module: `cmd_parity_check`

## Requirements
- R1: The block counts the high bits in the 22-bit word made of `cmd_addr`, `cmd_bank`, `cmd_ras`, `cmd_cas` and `cmd_we`. It passes the word (`perr_n` stays high) when the count is even and the parity bit is 0, and also when the count is odd and the parity bit is 1.
- R2: The block flags an error (`perr_n` low) when the count is even and the parity bit is 1, and also when the count is odd and the parity bit is 0.
- R3: The parity bit for a word is the value on `par_late` at the clock edge after the edge that captured the word. The value on `par_late` at the word's own edge has no effect on that word's result.
- R4: A word is checked only if at least one bit of `cs_n` was 0 at the edge that captured it. A word captured with `cs_n` = 4'b1111 always passes. The `cs_n` value present when the parity bit arrives does not decide whether that word is checked.
- R5: A word's result reaches `perr_n` on the third rising edge after the word was captured. A deselect word also takes three edges.
- R6: After a single failing result, `perr_n` stays low for exactly two clock cycles and then returns high.
- R7: If a failing result arrives while `perr_n` is low, the two-cycle window restarts from that result, and `perr_n` stays low without a break.
- R8: While `rst_n` is low, `perr_n` is high and all pipeline state is cleared. After `rst_n` is released, `perr_n` stays high until a failing, checked result reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_addr | input | 16 | Address bits of the command word |
| cmd_bank | input | 3 | Bank address bits of the command word |
| cmd_ras | input | 1 | RAS line, counted at its electrical level |
| cmd_cas | input | 1 | CAS line, counted at its electrical level |
| cmd_we | input | 1 | WE line, counted at its electrical level |
| cs_n | input | 4 | Active-low chip selects, captured with the word |
| par_late | input | 1 | Parity bit for the word captured one edge earlier |
| perr_n | output | 1 | Active-low parity error flag |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 3 bank bits, 4 chip selects, an output latency of three edges and a two-cycle hold. With these values every timing point is a short, hand-countable cycle offset. Each test can therefore look at the flag one cycle before, during and one cycle after the hold window. The tests cover words spaced one, two and three cycles apart, which separates a restarted window from two distinct windows with a high cycle between them. The tests also drive opposite parity values on the word's own edge and on the following edge, and change the chip selects between those two edges, so that a misaligned parity bit or a wrongly sampled chip select produces a visibly different result.

// File: rtl/cmd_parity_check.sv
`timescale 1ns/1ps
module cmd_parity_check #(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 3,
  parameter int CS_W     = 4,
  parameter int OUT_LAT  = 3,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_ras,
  input  logic              cmd_cas,
  input  logic              cmd_we,
  input  logic [CS_W-1:0]   cs_n,
  input  logic              par_late,
  output logic              perr_n
);
  localparam int WORD_W = ADDR_W + BANK_W + 3;
  localparam int PIPE_D = OUT_LAT - 1;
  localparam int CNT_W  = $clog2(HOLD_CYC + 1);

  logic [WORD_W-1:0] word;
  logic              w_odd, w_qual;
  logic [PIPE_D-1:0] pipe;
  logic [CNT_W-1:0]  hold_cnt;
  logic              pipe_last;

  assign word      = {cmd_we, cmd_cas, cmd_ras, cmd_bank, cmd_addr};
  assign pipe_last = pipe[PIPE_D-1];
  assign perr_n    = (hold_cnt == '0);

  // word stage: bit sum and chip-select qualifier travel together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_odd  <= 1'b0;
      w_qual <= 1'b0;
    end else begin
      w_odd  <= ^word;
      w_qual <= ~(&cs_n);
    end
  end

  // late parity joins here, then the result walks to the output
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= w_qual & (w_odd ^ par_late);
      for (int i = 1; i < PIPE_D; i++) pipe[i] <= pipe[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_cnt <= '0;
    else if (pipe_last)      hold_cnt <= CNT_W'(HOLD_CYC);
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  // R8
  reset_high_chk: assert property (@(posedge clk) !rst_n |-> perr_n);
  // R4
  desel_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !w_qual |=> !pipe[0]);
  // R5
  result_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pipe_last) |-> !perr_n);
  // R6
  hold_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_n) |=> !perr_n);
  // R8
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_n) |-> $past(pipe_last));
  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_n && !pipe_last) |=> perr_n);
endmodule

// File: tb/cmd_parity_check_test.sv
`timescale 1ns/1ps
module cmd_parity_check_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] d = '0;
  logic [3:0]  cs_n = 4'hf;
  logic        par = 1'b0;
  logic        perr_n;
  int total = 0, bad = 0, n = 0;
  logic obs [0:31];
  bit done = 0;

  cmd_parity_check uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_addr(d[15:0]), .cmd_bank(d[18:16]),
    .cmd_ras(d[19]), .cmd_cas(d[20]), .cmd_we(d[21]),
    .cs_n(cs_n), .par_late(par), .perr_n(perr_n)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: perr_n got=%b exp=%b", tag, got, exp);
    end
  endtask

  // samples perr_n at the falling edge, then drives the next cycle
  task automatic cyc(input logic [21:0] dd, input logic [3:0] cc, input logic pp);
    @(negedge clk);
    obs[n] = perr_n;
    n++;
    d = dd; cs_n = cc; par = pp;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc('0, 4'hf, 1'b0);
  endtask

  task automatic win(input int lo, input int hi, input logic exp, input string tag);
    for (int i = lo; i <= hi; i++) chk(obs[i], exp, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    d = '0; cs_n = 4'hf; par = 1'b0;
    repeat (2) @(negedge clk);
    chk(perr_n, 1'b1, "R8 reset level");
    rst_n = 1'b1;
    idle(3);
    n = 0;
  endtask

  // one word, wrong-sense parity on its own edge, correct bit one edge later
  task automatic one_word(input logic [21:0] dd, input logic [3:0] cc, input logic pp,
                          input string tag);
    logic fail;
    fail = (cc != 4'hf) && ((^dd) ^ pp);
    n = 0;
    cyc(dd, cc, ~pp);
    cyc('0, 4'hf, pp);
    idle(5);
    chk(obs[3], 1'b1, {tag, " R5 before"});
    win(4, 5, !fail, {tag, " R6 window"});
    chk(obs[6], 1'b1, {tag, " R6 after"});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    #1;
    chk(perr_n, 1'b1, "R8 during reset");
    do_reset();
    idle(4);
    win(0, 3, 1'b1, "R8 high after release");
  endtask

  task automatic t_patterns();
    one_word(22'h000003, 4'he, 1'b0, "R1 even/0");
    one_word(22'h000007, 4'hd, 1'b1, "R1 odd/1");
    one_word(22'h3fffff, 4'h0, 1'b0, "R1 all ones");
    one_word(22'h000003, 4'hb, 1'b1, "R2 even/1");
    one_word(22'h380000, 4'h7, 1'b0, "R2 ras/cas/we odd/0");
    one_word(22'h070000, 4'he, 1'b0, "R2 bank bits R3");
  endtask

  task automatic t_desel();
    one_word(22'h000001, 4'hf, 1'b0, "R4 deselect bad parity");
    // deselected faulty word followed by a selected good word during the parity cycle
    n = 0;
    cyc(22'h000001, 4'hf, 1'b1);
    cyc('0, 4'h0, 1'b0);
    cyc('0, 4'hf, 1'b0);
    idle(5);
    win(0, 7, 1'b1, "R4 cs from word edge");
  endtask

  task automatic t_b2b();
    n = 0;
    cyc(22'h000001, 4'he, 1'b1);
    cyc(22'h000002, 4'he, 1'b0);
    cyc('0, 4'hf, 1'b0);
    idle(6);
    chk(obs[3], 1'b1, "R5 b2b before");
    win(4, 6, 1'b0, "R7 b2b continuous");
    chk(obs[7], 1'b1, "R7 b2b after");
  endtask

  task automatic t_gap(input int g);
    n = 0;
    cyc(22'h000001, 4'he, 1'b1);
    cyc('0, 4'hf, 1'b0);
    for (int i = 2; i < g; i++) cyc('0, 4'hf, 1'b0);
    cyc(22'h000004, 4'h7, 1'b0);
    cyc('0, 4'hf, 1'b0);
    idle(7);
    if (g == 2) begin
      win(4, 7, 1'b0, "R7 restart gap2");
      chk(obs[8], 1'b1, "R7 gap2 after");
    end else begin
      win(4, 5, 1'b0, "R6 first window gap3");
      chk(obs[6], 1'b1, "R6 high between gap3");
      win(7, 8, 1'b0, "R6 second window gap3");
      chk(obs[9], 1'b1, "R6 gap3 after");
    end
  endtask

  task automatic t_reset_mid();
    n = 0;
    cyc(22'h000001, 4'he, 1'b1);
    cyc('0, 4'hf, 1'b0);
    idle(3);
    chk(obs[4], 1'b0, "R2 before mid reset");
    rst_n = 1'b0;
    #1;
    chk(perr_n, 1'b1, "R8 reset cuts hold");
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    idle(5);
    win(0, 4, 1'b1, "R8 stays high after release");
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_desel();
    t_b2b();
    t_gap(2);
    t_gap(3);
    t_reset_mid();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule